// File: doc/BRIEF.md
# Operating-Mode Configuration Controller

This block owns the operating mode of a speech-compression device: which coding rate the codec core runs at, which of two external audio converter types is attached, and how fast the host serial port runs. It also decodes that mode for the rest of the chip. The first clock edge after reset is released copies a set of board-level strap pins into the mode registers. The straps are not looked at again after that edge. From then on, the mode can be changed at run time by already-parsed configuration commands, each carrying a command type and a small argument.

The outputs are the 2-bit rate code, a bypass flag, the codec select and a clock divisor for the serial port. The bypass flag marks the rate code that skips compression and sends captured samples straight back to playback. A baud change from software is held back until the serial transmitter reports idle, so that a character already being sent is not broken. Framing, checksums and the serial port itself live elsewhere.

Top module: `cfg_mode_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are: rate code 00, bypass flag low, codec select 0, the divisor for baud code 00, and error flag low.
- R2: The first rising clock edge after reset is released loads the rate, codec and baud fields from the strap pins. No command is accepted at that edge.
- R3: After the strap load, changes on the strap pins have no effect on any output.
- R4: A command of type 0x01 sets the rate field to argument bits [1:0] at the next edge. The other fields are left unchanged.
- R5: A command of type 0x02 sets the codec select to argument bit 0 at the next edge. The other fields are left unchanged.
- R6: A command of type 0x03 stores argument bits [1:0] as a pending baud code. The pending code becomes active at the first later edge that samples txIdle high. A newer baud command replaces a pending code that has not yet become active.
- R7: The bypass flag is high exactly when the rate code is 11. Codes 00, 01 and 10 are the 2400, 1200 and 600 bps coding rates.
- R8: baudDiv equals CLK_HZ divided by the active baud rate, rounded to the nearest integer. The baud codes map as 00 = 115200, 01 = 9600, 10 = 4800 and 11 = 2400.
- R9: A command whose type is not 0x01, 0x02 or 0x03 changes no field and raises cmdErr for exactly the one cycle after the edge that took it.
- R10: When cmdValid is low, cmdType and cmdArg have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapRate | input | 2 | Strap level for the coding rate |
| strapCodec | input | 1 | Strap level for the codec select |
| strapBaud | input | 2 | Strap level for the baud code |
| cmdValid | input | 1 | A parsed command is present this cycle |
| cmdType | input | 8 | Command type byte |
| cmdArg | input | 2 | Command argument |
| txIdle | input | 1 | Serial transmitter has no character in flight |
| rateCode | output | 2 | Active rate code |
| loopMode | output | 1 | Bypass (playback loop) mode |
| codecSel | output | 1 | Active external codec select |
| baudDiv | output | DIV_W | Serial clock divisor |
| cmdErr | output | 1 | One-cycle pulse for an unknown command type |

## Verification
The hardest situation to reach from the ports is a baud command that is waiting for the transmitter while other events pile up: a second baud command that replaces it, a rate or codec write in the same cycle, or an idle cycle that falls on the very edge a new baud command arrives. Directed sequences hold txIdle low across several baud commands and then release it. A long random phase drives txIdle at about fifty percent alongside a mix of valid, invalid and absent commands, so that these overlaps occur many times. A second reset with different strap levels, followed by strap toggling, shows that the straps are sampled once.

// File: rtl/cfg_mode_pkg.sv
package cfg_mode_pkg;

  localparam int unsigned TYPE_W = 8;
  localparam int unsigned ARG_W  = 2;

  localparam logic [TYPE_W-1:0] CMD_RATE  = 8'h01;
  localparam logic [TYPE_W-1:0] CMD_CODEC = 8'h02;
  localparam logic [TYPE_W-1:0] CMD_BAUD  = 8'h03;

  typedef enum logic [1:0] {
    RATE_2400 = 2'b00,
    RATE_1200 = 2'b01,
    RATE_600  = 2'b10,
    RATE_LOOP = 2'b11
  } rate_e;

  typedef enum logic {
    ST_SAMPLE = 1'b0,
    ST_RUN    = 1'b1
  } ctl_state_e;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic             loadStrap;
    logic             wrRate;
    logic             wrCodec;
    logic             wrBaud;
    logic [ARG_W-1:0] arg;
  } cfg_strobe_t;

  function automatic int unsigned baudOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return 115200;
      2'b01:   return 9600;
      2'b10:   return 4800;
      default: return 2400;
    endcase
  endfunction

endpackage

// File: rtl/cfg_mode_ctl.sv
module cfg_mode_ctl
  import cfg_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [TYPE_W-1:0] cmdType,
  input  logic [ARG_W-1:0]  cmdArg,
  output cfg_strobe_t       strb,
  output logic              cmdErr
);

  ctl_state_e state;
  logic       knownType;
  logic       errR;

  // One sampling cycle after reset, then run forever.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SAMPLE;
    else       state <= ST_RUN;
  end

  assign knownType = (cmdType == CMD_RATE) || (cmdType == CMD_CODEC) ||
                     (cmdType == CMD_BAUD);

  always_comb begin
    strb           = '0;
    strb.loadStrap = (state == ST_SAMPLE);
    strb.arg       = cmdArg;
    if (state == ST_RUN && cmdValid) begin
      case (cmdType)
        CMD_RATE:  strb.wrRate  = 1'b1;
        CMD_CODEC: strb.wrCodec = 1'b1;
        CMD_BAUD:  strb.wrBaud  = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errR <= 1'b0;
    else       errR <= (state == ST_RUN) && cmdValid && !knownType;
  end

  assign cmdErr = errR;

endmodule

// File: rtl/cfg_mode_dp.sv
module cfg_mode_dp
  import cfg_mode_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_strobe_t      strb,
  input  logic [1:0]       strapRate,
  input  logic             strapCodec,
  input  logic [1:0]       strapBaud,
  input  logic             txIdle,
  output logic [1:0]       rateCode,
  output logic             loopMode,
  output logic             codecSel,
  output logic [DIV_W-1:0] baudDiv
);

  localparam int unsigned N_BAUD = 4;

  rate_e      rateR;
  logic       codecR;
  logic [1:0] baudR;
  logic [1:0] pendR;
  logic       pendV;
  logic       applyBaud;

  logic [DIV_W-1:0] divTab [N_BAUD];

  // Rounded divisor per baud code, fixed at elaboration.
  for (genvar g = 0; g < N_BAUD; g++) begin : g_div
    localparam int unsigned BAUD = baudOf(2'(g));
    localparam int unsigned DIVV = (CLK_HZ + BAUD / 2) / BAUD;
    assign divTab[g] = DIV_W'(DIVV);
  end

  assign applyBaud = pendV && txIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateR  <= RATE_2400;
      codecR <= 1'b0;
      baudR  <= 2'b00;
      pendR  <= 2'b00;
      pendV  <= 1'b0;
    end else if (strb.loadStrap) begin
      rateR  <= rate_e'(strapRate);
      codecR <= strapCodec;
      baudR  <= strapBaud;
      pendR  <= strapBaud;
      pendV  <= 1'b0;
    end else begin
      if (strb.wrRate)  rateR  <= rate_e'(strb.arg);
      if (strb.wrCodec) codecR <= strb.arg[0];
      if (applyBaud)    baudR  <= pendR;
      if (strb.wrBaud) begin
        pendR <= strb.arg;
        pendV <= 1'b1;
      end else if (applyBaud) begin
        pendV <= 1'b0;
      end
    end
  end

  assign rateCode = rateR;
  assign loopMode = (rateR == RATE_LOOP);
  assign codecSel = codecR;
  assign baudDiv  = divTab[baudR];

endmodule

// File: rtl/cfg_mode_ctrl.sv
module cfg_mode_ctrl
  import cfg_mode_pkg::*;
#(
  parameter  int unsigned CLK_HZ = 100_000_000,
  localparam int unsigned DIV_W  = $clog2(CLK_HZ / 2400 + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        strapRate,
  input  logic              strapCodec,
  input  logic [1:0]        strapBaud,
  input  logic              cmdValid,
  input  logic [TYPE_W-1:0] cmdType,
  input  logic [ARG_W-1:0]  cmdArg,
  input  logic              txIdle,
  output logic [1:0]        rateCode,
  output logic              loopMode,
  output logic              codecSel,
  output logic [DIV_W-1:0]  baudDiv,
  output logic              cmdErr
);

  cfg_strobe_t strb;

  cfg_mode_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdType  (cmdType),
    .cmdArg   (cmdArg),
    .strb     (strb),
    .cmdErr   (cmdErr)
  );

  cfg_mode_dp #(
    .CLK_HZ (CLK_HZ),
    .DIV_W  (DIV_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .strapRate  (strapRate),
    .strapCodec (strapCodec),
    .strapBaud  (strapBaud),
    .txIdle     (txIdle),
    .rateCode   (rateCode),
    .loopMode   (loopMode),
    .codecSel   (codecSel),
    .baudDiv    (baudDiv)
  );

endmodule

// File: rtl/cfg_mode_chk.sv
module cfg_mode_chk
  import cfg_mode_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        strapRate,
  input logic              strapCodec,
  input logic              cmdValid,
  input logic [TYPE_W-1:0] cmdType,
  input logic [ARG_W-1:0]  cmdArg,
  input logic              txIdle,
  input logic [1:0]        rateCode,
  input logic              loopMode,
  input logic              codecSel,
  input logic [DIV_W-1:0]  baudDiv,
  input logic              cmdErr
);

  logic started;
  logic known;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  assign known = (cmdType == CMD_RATE) || (cmdType == CMD_CODEC) ||
                 (cmdType == CMD_BAUD);

  p_strap_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    !started |=> (rateCode == $past(strapRate)) && (codecSel == $past(strapCodec)));

  p_strap_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    started && !(cmdValid && cmdType == CMD_CODEC) |=> $stable(codecSel));

  p_rate_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    started && cmdValid && cmdType == CMD_RATE |=> rateCode == $past(cmdArg));

  p_codec_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    started && cmdValid && cmdType == CMD_CODEC |=> codecSel == $past(cmdArg[0]));

  p_baud_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    started && !txIdle |=> $stable(baudDiv));

  p_loop_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    started && cmdValid && cmdType == CMD_RATE && cmdArg == 2'b11 |=> loopMode);

  p_loop_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    started && cmdValid && cmdType == CMD_RATE && cmdArg != 2'b11 |=> !loopMode);

  p_err_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    started && cmdValid && !known |=> cmdErr);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !cmdErr);

endmodule

bind cfg_mode_ctrl cfg_mode_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strapRate  (strapRate),
  .strapCodec (strapCodec),
  .cmdValid   (cmdValid),
  .cmdType    (cmdType),
  .cmdArg     (cmdArg),
  .txIdle     (txIdle),
  .rateCode   (rateCode),
  .loopMode   (loopMode),
  .codecSel   (codecSel),
  .baudDiv    (baudDiv),
  .cmdErr     (cmdErr)
);

// File: tb/cfg_mode_ctrl_bench.sv
module cfg_mode_ctrl_bench;
  import cfg_mode_pkg::*;

  localparam int CLK_HZ = 100_000_000;
  localparam int DIV_W  = $clog2(CLK_HZ / 2400 + 2);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       strapRate = '0;
  logic             strapCodec = 1'b0;
  logic [1:0]       strapBaud = '0;
  logic             cmdValid = 1'b0;
  logic [7:0]       cmdType = '0;
  logic [1:0]       cmdArg = '0;
  logic             txIdle = 1'b1;
  logic [1:0]       rateCode;
  logic             loopMode;
  logic             codecSel;
  logic [DIV_W-1:0] baudDiv;
  logic             cmdErr;

  int checks = 0;
  int errors = 0;

  // Expected state
  logic [1:0] mRate, mBaud, mPend;
  logic       mCodec, mPendV, mErr;

  cfg_mode_ctrl #(.CLK_HZ(CLK_HZ)) u_cfg_mode_ctrl (
    .clk(clk), .rstN(rstN), .strapRate(strapRate), .strapCodec(strapCodec),
    .strapBaud(strapBaud), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdArg(cmdArg), .txIdle(txIdle), .rateCode(rateCode),
    .loopMode(loopMode), .codecSel(codecSel), .baudDiv(baudDiv),
    .cmdErr(cmdErr)
  );

  always #5 clk = ~clk;

  function automatic int expDiv(input logic [1:0] s);
    int b;
    case (s)
      2'b00:   b = 115200;
      2'b01:   b = 9600;
      2'b10:   b = 4800;
      default: b = 2400;
    endcase
    return (CLK_HZ + b / 2) / b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "rateCode", int'(rateCode), int'(mRate));
    chk(req, "loopMode", int'(loopMode), int'(mRate == 2'b11));
    chk(req, "codecSel", int'(codecSel), int'(mCodec));
    chk(req, "baudDiv",  int'(baudDiv),  expDiv(mBaud));
    chk(req, "cmdErr",   int'(cmdErr),   int'(mErr));
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic v, input logic [7:0] t, input logic [1:0] a,
                      input logic idle, input string req);
    logic known;
    cmdValid = v; cmdType = t; cmdArg = a; txIdle = idle;
    known = (t == CMD_RATE) || (t == CMD_CODEC) || (t == CMD_BAUD);
    mErr = v && !known;
    if (v && t == CMD_RATE)  mRate  = a;
    if (v && t == CMD_CODEC) mCodec = a[0];
    if (mPendV && idle) begin
      mBaud  = mPend;
      mPendV = 1'b0;
    end
    if (v && t == CMD_BAUD) begin
      mPend  = a;
      mPendV = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    checkAll(req);
  endtask

  task automatic doReset(input logic [1:0] sr, input logic sc, input logic [1:0] sb);
    @(negedge clk);
    rstN = 1'b0; cmdValid = 1'b0; txIdle = 1'b1;
    strapRate = sr; strapCodec = sc; strapBaud = sb;
    repeat (2) @(negedge clk);
    mRate = 2'b00; mCodec = 1'b0; mBaud = 2'b00; mPend = 2'b00;
    mPendV = 1'b0; mErr = 1'b0;
    checkAll("R1");
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mRate = sr; mCodec = sc; mBaud = sb; mPend = sb;
    checkAll("R2");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));

    // R1, R2: reset values then strap load
    doReset(2'b10, 1'b1, 2'b11);

    // R3: straps move, outputs must not
    strapRate = 2'b01; strapCodec = 1'b0; strapBaud = 2'b01;
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 2'b00, 1'b1, "R3");

    // Second reset: bypass code from straps (R7), fastest baud (R8)
    doReset(2'b11, 1'b0, 2'b00);
    step(1'b0, 8'h00, 2'b00, 1'b1, "R7");

    // R4: rate writes, R7 bypass follows
    step(1'b1, CMD_RATE, 2'b01, 1'b1, "R4");
    step(1'b1, CMD_RATE, 2'b11, 1'b1, "R7");
    step(1'b1, CMD_RATE, 2'b00, 1'b1, "R4");

    // R5: codec writes
    step(1'b1, CMD_CODEC, 2'b01, 1'b1, "R5");
    step(1'b1, CMD_CODEC, 2'b10, 1'b1, "R5");

    // R6: baud held while busy, later command replaces pending one
    step(1'b1, CMD_BAUD, 2'b10, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 2'b00, 1'b0, "R6");
    step(1'b1, CMD_BAUD, 2'b01, 1'b0, "R6");
    step(1'b0, 8'h00, 2'b00, 1'b1, "R6");
    step(1'b0, 8'h00, 2'b00, 1'b1, "R6");

    // R8: every baud code
    for (int c = 0; c < 4; c++) begin
      step(1'b1, CMD_BAUD, 2'(c), 1'b1, "R8");
      step(1'b0, 8'h00, 2'b00, 1'b1, "R8");
    end

    // R9: unknown types pulse error for one cycle
    step(1'b1, 8'h7F, 2'b11, 1'b1, "R9");
    step(1'b0, 8'h7F, 2'b11, 1'b1, "R9");
    step(1'b1, 8'h00, 2'b01, 1'b1, "R9");
    step(1'b1, 8'h04, 2'b10, 1'b1, "R9");
    step(1'b0, 8'h00, 2'b00, 1'b1, "R9");

    // R10: valid low with meaningful type
    step(1'b0, CMD_RATE, 2'b10, 1'b1, "R10");
    step(1'b0, CMD_BAUD, 2'b11, 1'b1, "R10");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic       v;
      logic [7:0] t;
      logic [1:0] a;
      logic       idle;
      int         pick;
      v    = ($urandom % 4) != 0;
      pick = $urandom % 5;
      t    = (pick < 3) ? 8'(pick + 1) : 8'($urandom);
      a    = 2'($urandom);
      idle = ($urandom % 2) == 0;
      step(v, t, a, idle, "R4/R5/R6/R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule